// File: doc/BRIEF.md
# Vector Scaled Address Generator

This unit turns two vector operands into a vector of memory addresses in a single registered step. One operand holds a base address per lane, the other holds an offset per lane. Each offset is first widened according to a mode select, then multiplied by 1, 2, 4 or 8 through a left shift, and finally added to its base. Every lane is computed on every valid operation; there is no mask.

Three offset modes share one datapath. In native mode the lanes are 32 or 64 bits wide, chosen by a width select, and the whole lane of the offset is used as an unsigned value. In the two widening modes the lanes are always 64 bits, and only the low 32 bits of each offset lane are used, either sign-extended or zero-extended. An operation is refused when the core reports the restricted execution state without the full instruction set being enabled, or when the reserved mode code is presented. A refused operation raises the illegal flag and leaves the result register as it was.

Top module: `vec_addr_gen`

## Requirements
- R1: With off_mode 00 and elem_wide 0, each 32-bit lane i (bits 32i+31:32i of both operands and of the result) gives base + (offset << shift_amt) modulo 2^32, with no carry into the next lane.
- R2: With off_mode 00 and elem_wide 1, each 64-bit lane i (bits 64i+63:64i) gives base + (offset << shift_amt) modulo 2^64, the full 64-bit offset treated as unsigned.
- R3: With off_mode 01, lanes are 64 bits whatever elem_wide is, and the offset is bits 31:0 of the offset lane sign-extended to 64 bits; bits 63:32 of the offset lane have no effect.
- R4: With off_mode 10, lanes are 64 bits whatever elem_wide is, and the offset is bits 31:0 of the offset lane zero-extended to 64 bits; bits 63:32 of the offset lane have no effect.
- R5: shift_amt values 0, 1, 2 and 3 scale the extended offset by 1, 2, 4 and 8.
- R6: Sums that exceed the lane width wrap within the lane.
- R7: out_valid rises one cycle after in_valid and the result of that operation appears in the same cycle; reset clears out_valid, illegal and result_vec to zero.
- R8: An operation with streaming 1 and full_isa_en 0 is reported with out_valid 1 and illegal 1 and leaves result_vec unchanged; with full_isa_en 1 it completes normally.
- R9: An operation with off_mode 11 is reported with out_valid 1 and illegal 1 and leaves result_vec unchanged.
- R10: A legal operation reports illegal 0; a cycle without in_valid yields out_valid 0 and illegal 0 in the next cycle and leaves result_vec unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation request this cycle |
| base_vec | input | VLEN | Base address per lane |
| offs_vec | input | VLEN | Offset per lane |
| elem_wide | input | 1 | Native-mode lane width: 0 = 32 bits, 1 = 64 bits |
| off_mode | input | 2 | 00 native, 01 signed low 32, 10 unsigned low 32, 11 reserved |
| shift_amt | input | 2 | Left shift applied to the extended offset |
| streaming | input | 1 | Restricted execution state is active |
| full_isa_en | input | 1 | Full instruction set allowed in the restricted state |
| out_valid | output | 1 | Result of the previous cycle's request is present |
| result_vec | output | VLEN | Address vector |
| illegal | output | 1 | The previous request was refused |

## Verification
The only state is the output register, so a fault shows at the ports one cycle after the request that exposes it: a wrong lane selection or extension corrupts the affected lanes of result_vec immediately, and a refused operation that wrongly writes the register shows as a changed result_vec in that same cycle. The bench predicts every cycle from its own arithmetic, including held results across refused and idle cycles, so a stale or overwritten result is caught at the first cycle it differs. Carry leakage between packed 32-bit lanes is exposed by all-ones operands.

// File: rtl/vag_pkg.sv
package vag_pkg;

    typedef enum logic [1:0] {
        OFFS_NATIVE = 2'b00,
        OFFS_SX32   = 2'b01,
        OFFS_ZX32   = 2'b10,
        OFFS_RSVD   = 2'b11
    } offs_mode_e;

    localparam int unsigned NARROW_W = 32;
    localparam int unsigned WIDE_W   = 64;

endpackage

// File: rtl/vag_lane_narrow.sv
module vag_lane_narrow
    import vag_pkg::*;
(
    input  logic [NARROW_W-1:0] base_i,
    input  logic [NARROW_W-1:0] offs_i,
    input  logic [1:0]          shift_i,
    output logic [NARROW_W-1:0] addr_o
);

    logic [NARROW_W-1:0] scaled;

    always_comb begin
        scaled = offs_i << shift_i;
        addr_o = base_i + scaled;
    end

endmodule

// File: rtl/vag_lane_wide.sv
module vag_lane_wide
    import vag_pkg::*;
(
    input  logic [WIDE_W-1:0] base_i,
    input  logic [WIDE_W-1:0] offs_i,
    input  offs_mode_e        mode_i,
    input  logic [1:0]        shift_i,
    output logic [WIDE_W-1:0] addr_o
);

    localparam int unsigned HALF_W = WIDE_W / 2;

    logic [WIDE_W-1:0] ext;
    logic [WIDE_W-1:0] scaled;

    always_comb begin
        case (mode_i)
            OFFS_SX32: ext = {{HALF_W{offs_i[HALF_W-1]}}, offs_i[HALF_W-1:0]};
            OFFS_ZX32: ext = {{HALF_W{1'b0}}, offs_i[HALF_W-1:0]};
            default:   ext = offs_i;
        endcase
        scaled = ext << shift_i;
        addr_o = base_i + scaled;
    end

endmodule

// File: rtl/vag_legal.sv
module vag_legal
    import vag_pkg::*;
(
    input  offs_mode_e mode_i,
    input  logic       streaming_i,
    input  logic       full_isa_en_i,
    output logic       refuse_o
);

    logic state_block;
    logic mode_block;

    always_comb begin
        state_block = streaming_i & ~full_isa_en_i;
        mode_block  = (mode_i == OFFS_RSVD);
        refuse_o    = state_block | mode_block;
    end

endmodule

// File: rtl/vec_addr_gen.sv
module vec_addr_gen
    import vag_pkg::*;
#(
    parameter int unsigned VLEN = 256
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [VLEN-1:0] base_vec,
    input  logic [VLEN-1:0] offs_vec,
    input  logic            elem_wide,
    input  logic [1:0]      off_mode,
    input  logic [1:0]      shift_amt,
    input  logic            streaming,
    input  logic            full_isa_en,
    output logic            out_valid,
    output logic [VLEN-1:0] result_vec,
    output logic            illegal
);

    localparam int unsigned LANES_N = VLEN / NARROW_W;
    localparam int unsigned LANES_W = VLEN / WIDE_W;

    typedef struct packed {
        logic            valid;
        logic            illegal;
        logic [VLEN-1:0] result;
    } state_t;

    state_t state_d, state_q;

    offs_mode_e      mode_e;
    logic            refuse;
    logic [VLEN-1:0] narrow_res;
    logic [VLEN-1:0] wide_res;
    logic            use_wide;

    assign mode_e = offs_mode_e'(off_mode);

    vag_legal u_legal (
        .mode_i        (mode_e),
        .streaming_i   (streaming),
        .full_isa_en_i (full_isa_en),
        .refuse_o      (refuse)
    );

    for (genvar i = 0; i < LANES_N; i++) begin : g_narrow
        vag_lane_narrow u_lane (
            .base_i  (base_vec[i*NARROW_W +: NARROW_W]),
            .offs_i  (offs_vec[i*NARROW_W +: NARROW_W]),
            .shift_i (shift_amt),
            .addr_o  (narrow_res[i*NARROW_W +: NARROW_W])
        );
    end

    for (genvar j = 0; j < LANES_W; j++) begin : g_wide
        vag_lane_wide u_lane (
            .base_i  (base_vec[j*WIDE_W +: WIDE_W]),
            .offs_i  (offs_vec[j*WIDE_W +: WIDE_W]),
            .mode_i  (mode_e),
            .shift_i (shift_amt),
            .addr_o  (wide_res[j*WIDE_W +: WIDE_W])
        );
    end

    always_comb begin
        use_wide        = elem_wide | (mode_e != OFFS_NATIVE);
        state_d         = state_q;
        state_d.valid   = in_valid;
        state_d.illegal = in_valid & refuse;
        if (in_valid && !refuse) begin
            state_d.result = use_wide ? wide_res : narrow_res;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_valid  = state_q.valid;
    assign illegal    = state_q.illegal;
    assign result_vec = state_q.result;

    AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R7
    AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !illegal)); // R10
    AST_REFUSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && illegal) |-> $stable(result_vec)); // R8
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(result_vec)); // R10
    AST_RSVD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && off_mode == 2'b11) |=> illegal); // R9
    AST_STATE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && streaming && !full_isa_en) |=> illegal); // R8
    AST_LEGAL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && off_mode != 2'b11 && !(streaming && !full_isa_en)) |=> !illegal); // R10

endmodule

// File: tb/vec_addr_gen_bench.sv
module vec_addr_gen_bench;

    localparam int unsigned VLEN = 256;
    localparam int unsigned N32  = VLEN / 32;
    localparam int unsigned N64  = VLEN / 64;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic [VLEN-1:0] base_vec = '0;
    logic [VLEN-1:0] offs_vec = '0;
    logic            elem_wide = 1'b0;
    logic [1:0]      off_mode = 2'b00;
    logic [1:0]      shift_amt = 2'b00;
    logic            streaming = 1'b0;
    logic            full_isa_en = 1'b0;
    logic            out_valid;
    logic [VLEN-1:0] result_vec;
    logic            illegal;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic            exp_valid = 1'b0;
    logic            exp_ill   = 1'b0;
    logic [VLEN-1:0] exp_res   = '0;
    string           chk_tag   = "R7";

    always #5 clk = ~clk;

    vec_addr_gen #(.VLEN(VLEN)) u_vec_addr_gen (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .base_vec    (base_vec),
        .offs_vec    (offs_vec),
        .elem_wide   (elem_wide),
        .off_mode    (off_mode),
        .shift_amt   (shift_amt),
        .streaming   (streaming),
        .full_isa_en (full_isa_en),
        .out_valid   (out_valid),
        .result_vec  (result_vec),
        .illegal     (illegal)
    );

    function automatic logic [VLEN-1:0] rand_vec();
        logic [VLEN-1:0] v;
        for (int k = 0; k < N32; k++) v[k*32 +: 32] = $urandom;
        return v;
    endfunction

    function automatic logic [VLEN-1:0] model(logic [VLEN-1:0] b, logic [VLEN-1:0] o,
                                              logic w, logic [1:0] m, logic [1:0] s);
        logic [VLEN-1:0] r;
        longint unsigned mul;
        mul = 64'd1 << s;
        if (m == 2'b00 && !w) begin
            for (int k = 0; k < N32; k++) begin
                longint unsigned t;
                t = longint'(b[k*32 +: 32]) + longint'(o[k*32 +: 32]) * mul;
                r[k*32 +: 32] = t[31:0];
            end
        end else begin
            for (int k = 0; k < N64; k++) begin
                longint unsigned ov;
                longint signed   sv;
                if (m == 2'b01) begin
                    sv = longint'(int'(o[k*64 +: 32]));
                    ov = longint'(sv);
                end else if (m == 2'b10) begin
                    ov = longint'(o[k*64 +: 32]);
                end else begin
                    ov = o[k*64 +: 64];
                end
                r[k*64 +: 64] = b[k*64 +: 64] + ov * mul;
            end
        end
        return r;
    endfunction

    task automatic compare();
        checks++;
        if (out_valid !== exp_valid) begin
            fails++;
            $display("FAIL %s out_valid act=%b exp=%b", chk_tag, out_valid, exp_valid);
        end
        checks++;
        if (illegal !== exp_ill) begin
            fails++;
            $display("FAIL %s illegal act=%b exp=%b", chk_tag, illegal, exp_ill);
        end
        checks++;
        if (result_vec !== exp_res) begin
            fails++;
            $display("FAIL %s result act=%h exp=%h", chk_tag, result_vec, exp_res);
        end
    endtask

    task automatic step(logic v, logic [VLEN-1:0] b, logic [VLEN-1:0] o, logic w,
                        logic [1:0] m, logic [1:0] s, logic st, logic fa, string tag);
        logic refuse;
        @(negedge clk);
        compare();
        in_valid = v; base_vec = b; offs_vec = o; elem_wide = w;
        off_mode = m; shift_amt = s; streaming = st; full_isa_en = fa;
        refuse = (st && !fa) || (m == 2'b11);
        exp_valid = v;
        exp_ill   = v && refuse;
        if (v && !refuse) exp_res = model(b, o, w, m, s);
        chk_tag = tag;
    endtask

    function automatic string tag_of(logic w, logic [1:0] m, logic st, logic fa);
        if (st && !fa) return "R8";
        case (m)
            2'b00:   return w ? "R2" : "R1";
            2'b01:   return "R3";
            2'b10:   return "R4";
            default: return "R9";
        endcase
    endfunction

    initial begin
        logic [VLEN-1:0] ones;
        logic [VLEN-1:0] neg_off;
        ones = '1;
        for (int k = 0; k < N64; k++) begin
            neg_off[k*64 +: 32] = 32'hFFFF_FFF0 - k;
            neg_off[k*64+32 +: 32] = 32'h1234_5678;
        end
        chk_tag = "R7";
        repeat (2) @(negedge clk);
        compare();
        rst_n = 1'b1;
        // R1 and R5: packed narrow lanes over every scale
        for (int s = 0; s < 4; s++) step(1, rand_vec(), rand_vec(), 0, 2'b00, 2'(s), 0, 0, "R5");
        // R6: all-ones narrow lanes, carry must stay in lane
        step(1, ones, ones, 0, 2'b00, 2'd3, 0, 0, "R6");
        // R2 and R6: wide native lanes
        for (int s = 0; s < 4; s++) step(1, rand_vec(), rand_vec(), 1, 2'b00, 2'(s), 0, 0, "R2");
        step(1, ones, ones, 1, 2'b00, 2'd3, 0, 0, "R6");
        // R3: negative signed offset, upper half junk, width select ignored
        for (int s = 0; s < 4; s++) step(1, rand_vec(), neg_off, 0, 2'b01, 2'(s), 0, 0, "R3");
        // R4: same offset zero-extended
        for (int s = 0; s < 4; s++) step(1, rand_vec(), neg_off, 0, 2'b10, 2'(s), 0, 0, "R4");
        // R8: refused in restricted state, then allowed with full set
        step(1, rand_vec(), rand_vec(), 0, 2'b00, 2'd1, 1, 0, "R8");
        step(1, rand_vec(), rand_vec(), 1, 2'b00, 2'd2, 1, 1, "R8");
        // R9: reserved mode refused
        step(1, rand_vec(), rand_vec(), 1, 2'b11, 2'd0, 0, 0, "R9");
        // R10: idle cycles hold result
        step(0, rand_vec(), rand_vec(), 0, 2'b00, 2'd1, 0, 0, "R10");
        step(0, rand_vec(), rand_vec(), 1, 2'b01, 2'd3, 0, 1, "R10");
        // R7: back to back after idle
        step(1, rand_vec(), rand_vec(), 0, 2'b10, 2'd2, 0, 0, "R7");
        for (int n = 0; n < 400; n++) begin
            logic w; logic [1:0] m; logic st; logic fa; logic v;
            w = 1'($urandom); m = 2'($urandom); st = ($urandom % 4) == 0;
            fa = 1'($urandom); v = ($urandom % 5) != 0;
            step(v, rand_vec(), rand_vec(), w, m, 2'($urandom), st, fa,
                 v ? tag_of(w, m, st, fa) : "R10");
        end
        step(0, '0, '0, 0, 2'b00, 2'd0, 0, 0, "R10");
        @(negedge clk);
        compare();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule